// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Port

This block is the master side of an external memory port whose sixteen bidirectional pins carry both the address and the data. It has a 24-bit address space and can move either one byte or one 16-bit word per access. An internal requester hands it single read or write requests over a valid/ready handshake, together with the address, write data and a width select. The port then runs the access on the pins and returns a one-cycle completion pulse, carrying read data or an error flag.

The address bits that do not fit beside the data are held by an external latch, which is loaded while the latch strobe is active. In byte mode the latch holds address bits 23..8, and bits 7..0 travel on the upper pin byte during the strobe. In word mode the latch holds bits 15..0. The port remembers which latched value the external latch already holds and skips the latch phase when the next access needs the same value. Each access phase has a programmable length. The latch strobe polarity can be changed, and a disable input releases all pins to other functions.

Top module: `mux_ad_port`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, ad_oe is all zero, rd_n and wr_n are 1, ale_pin is 0, rsp_done is 0 and req_ready is 1.
- R2: In byte mode (req_mode16=0) a latch phase takes place only when address bits 23..8 differ from those of the previous completed-or-started access, or when there has been no such access since reset, a width change or a disable. During the latch phase ad_out carries address bits 23..8.
- R3: In word mode (req_mode16=1) the comparison covers address bits 15..0 only, and the latch phase drives address bits 15..0 on ad_out. Bits 23..16 play no part in it.
- R4: ale_pin is asserted high when cfg_ale_low=0 and asserted low when cfg_ale_low=1. The setting is sampled only while the port is idle, and reset selects active high.
- R5: A read holds rd_n low for max(1,t_strobe) cycles, and rd_n and wr_n are never low together. In word mode all pins are released (ad_oe=0). In byte mode ad_oe=16'hFF00, and ad_out[15:8] carries address bits 7..0. rsp_rdata is ad_in (word mode) or {8'h00, ad_in[7:0]} (byte mode), sampled in the last cycle that rd_n is low.
- R6: A write holds wr_n low for max(1,t_strobe) cycles with all pins driven. The pins carry the write data in word mode, or {address[7:0], wdata[7:0]} in byte mode.
- R7: An access runs, in order: latch phase (if needed) of max(1,t_ale) cycles; address hold of max(1,t_hold) cycles, with all pins driving the address and no strobe; strobe; recovery of max(1,t_recover) cycles, with pins released and no strobe. The port then becomes ready again.
- R8: rsp_done pulses for exactly one cycle, in the cycle after the last strobe cycle, with rsp_err=0.
- R9: While port_disable=1, rd_n and wr_n are 1, ale_pin is at its inactive level and ad_oe is 0. A request accepted while disabled produces rsp_done with rsp_err=1 and rsp_rdata=0 in the next cycle, with no pin activity. An access in progress when port_disable rises ends with the same error response. Disabling forgets the remembered latch value.
- R10: req_ready is 1 only while no access is running and no response is pending. It is 0 in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ale_low | input | 1 | 1 selects active-low latch strobe |
| t_ale | input | 4 | Latch phase length in cycles (0 acts as 1) |
| t_hold | input | 4 | Address hold length in cycles (0 acts as 1) |
| t_strobe | input | 4 | Read/write strobe length in cycles (0 acts as 1) |
| t_recover | input | 4 | Recovery length in cycles (0 acts as 1) |
| port_disable | input | 1 | Hands the pins to other functions |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode16 | input | 1 | 1 = word mode, 0 = byte mode |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an error |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ad_out | output | 16 | Pin output values |
| ad_oe | output | 16 | Per-pin output enable |
| ad_in | input | 16 | Pin input values |
| ale_pin | output | 1 | External address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach is a disable that arrives in the middle of an access. The port has to drop the strobe, answer with an error, and then forget the remembered latch value, so the next access to the same address must latch again. The stimulus starts a read with a long strobe, raises the disable after a fixed number of cycles, and then repeats the same address. Latch skipping is covered by address sequences that change only the bits below the latched field, only the latched field, and only bits outside it in word mode, with a width change in between. A bench-side model of the external latch rebuilds each full address from the pins, so every read value also confirms the address multiplexing.

// File: rtl/mux_ad_pkg.sv
package mux_ad_pkg;
   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_ALE     = 3'd1,
      PH_HOLD    = 3'd2,
      PH_STROBE  = 3'd3,
      PH_RECOVER = 3'd4
   } mux_ad_phase_e;
endpackage

// File: rtl/mux_ad_tag_track.sv
module mux_ad_tag_track #(
   parameter int AD_W   = 16,
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              inval,
   input  logic              mode16,
   input  logic [ADDR_W-1:0] addr,
   output logic              need_latch
);
   localparam int TAG_W = AD_W;

   logic [TAG_W-1:0] cur_tag;
   logic [TAG_W-1:0] prev_tag;
   logic             prev_mode;
   logic             prev_ok;

   assign cur_tag = mode16 ? addr[AD_W-1:0] : addr[ADDR_W-1 -: AD_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ok   <= 1'b0;
         prev_tag  <= '0;
         prev_mode <= 1'b0;
      end else if (inval) begin
         prev_ok   <= 1'b0;
      end else if (load) begin
         prev_ok   <= 1'b1;
         prev_tag  <= cur_tag;
         prev_mode <= mode16;
      end
   end

   assign need_latch = !prev_ok || (prev_mode != mode16) || (prev_tag != cur_tag);

   // R2
   repeat_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !inval) |=> ((addr != $past(addr)) || (mode16 != $past(mode16)) || !need_latch));
endmodule

// File: rtl/mux_ad_seq.sv
module mux_ad_seq
   import mux_ad_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             need_ale,
   input  logic             abort,
   input  logic [CNT_W-1:0] t_ale,
   input  logic [CNT_W-1:0] t_hold,
   input  logic [CNT_W-1:0] t_strobe,
   input  logic [CNT_W-1:0] t_recover,
   output mux_ad_phase_e    phase,
   output logic             phase_last
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   mux_ad_phase_e    nxt_phase;
   logic [CNT_W-1:0] cnt, nxt_cnt;

   function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] t);
      return (t == '0) ? '0 : (t - ONE);
   endfunction

   assign phase_last = (phase != PH_IDLE) && (cnt == '0);

   always_comb begin
      nxt_phase = phase;
      nxt_cnt   = cnt;
      if (abort) begin
         nxt_phase = PH_IDLE;
         nxt_cnt   = '0;
      end else if (phase == PH_IDLE) begin
         if (start) begin
            if (need_ale) begin
               nxt_phase = PH_ALE;
               nxt_cnt   = span(t_ale);
            end else begin
               nxt_phase = PH_HOLD;
               nxt_cnt   = span(t_hold);
            end
         end
      end else if (cnt != '0) begin
         nxt_cnt = cnt - ONE;
      end else begin
         unique case (phase)
            PH_ALE: begin
               nxt_phase = PH_HOLD;
               nxt_cnt   = span(t_hold);
            end
            PH_HOLD: begin
               nxt_phase = PH_STROBE;
               nxt_cnt   = span(t_strobe);
            end
            PH_STROBE: begin
               nxt_phase = PH_RECOVER;
               nxt_cnt   = span(t_recover);
            end
            default: begin
               nxt_phase = PH_IDLE;
               nxt_cnt   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         phase <= nxt_phase;
         cnt   <= nxt_cnt;
      end
   end

   // R7
   ale_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ALE && phase_last && !abort) |=> (phase == PH_HOLD));

   // R5
   strobe_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STROBE && !phase_last && !abort) |=> (phase == PH_STROBE));
endmodule

// File: rtl/mux_ad_lanes.sv
module mux_ad_lanes
   import mux_ad_pkg::*;
#(
   parameter int AD_W   = 16,
   parameter int ADDR_W = 24
) (
   input  mux_ad_phase_e     phase,
   input  logic              write,
   input  logic              mode16,
   input  logic [ADDR_W-1:0] addr,
   input  logic [AD_W-1:0]   wdata,
   output logic [AD_W-1:0]   ad_out,
   output logic [AD_W-1:0]   ad_oe
);
   localparam int LANES = AD_W / 8;

   logic [AD_W-1:0] abus;
   logic [7:0]      lane_val [LANES];
   logic            lane_en  [LANES];

   assign abus = mode16 ? addr[AD_W-1:0] : addr[ADDR_W-1 -: AD_W];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_data
         always_comb begin
            lane_val[l] = '0;
            lane_en[l]  = 1'b0;
            unique case (phase)
               PH_ALE, PH_HOLD: begin
                  lane_val[l] = abus[l*8 +: 8];
                  lane_en[l]  = 1'b1;
               end
               PH_STROBE: begin
                  lane_val[l] = wdata[l*8 +: 8];
                  lane_en[l]  = write;
               end
               default: ;
            endcase
         end
      end else begin : g_shared
         always_comb begin
            lane_val[l] = '0;
            lane_en[l]  = 1'b0;
            unique case (phase)
               PH_ALE, PH_HOLD: begin
                  lane_val[l] = abus[l*8 +: 8];
                  lane_en[l]  = 1'b1;
               end
               PH_STROBE: begin
                  if (mode16) begin
                     lane_val[l] = wdata[l*8 +: 8];
                     lane_en[l]  = write;
                  end else begin
                     lane_val[l] = addr[(l-1)*8 +: 8];
                     lane_en[l]  = 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
      assign ad_out[l*8 +: 8] = lane_val[l];
      assign ad_oe[l*8 +: 8]  = {8{lane_en[l]}};
   end
endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port
   import mux_ad_pkg::*;
#(
   parameter int AD_W   = 16,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ale_low,
   input  logic [CNT_W-1:0]  t_ale,
   input  logic [CNT_W-1:0]  t_hold,
   input  logic [CNT_W-1:0]  t_strobe,
   input  logic [CNT_W-1:0]  t_recover,
   input  logic              port_disable,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_mode16,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [AD_W-1:0]   req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [AD_W-1:0]   rsp_rdata,
   output logic [AD_W-1:0]   ad_out,
   output logic [AD_W-1:0]   ad_oe,
   input  logic [AD_W-1:0]   ad_in,
   output logic              ale_pin,
   output logic              rd_n,
   output logic              wr_n
);
   if (AD_W % 8 != 0 || AD_W < 16) begin : g_bad_pins
      $error("mux_ad_port: AD_W must be a multiple of 8 and at least 16");
   end
   if (ADDR_W != AD_W + 8) begin : g_bad_addr
      $error("mux_ad_port: ADDR_W must equal AD_W + 8");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("mux_ad_port: CNT_W must be positive");
   end

   mux_ad_phase_e     phase;
   logic              phase_last;
   logic              need_ale;
   logic              accept, start, reject, abort, finish;
   logic [ADDR_W-1:0] q_addr;
   logic [AD_W-1:0]   q_wdata;
   logic              q_write, q_mode16;
   logic              pol_q;
   logic              done_q, err_q;
   logic [AD_W-1:0]   rdata_q;
   logic [AD_W-1:0]   cap;
   logic [AD_W-1:0]   lane_out, lane_oe;

   assign req_ready = (phase == PH_IDLE) && !done_q;
   assign accept    = req_valid && req_ready;
   assign start     = accept && !port_disable;
   assign reject    = accept && port_disable;
   assign abort     = port_disable && (phase != PH_IDLE);
   assign finish    = (phase == PH_STROBE) && phase_last && !port_disable;

   mux_ad_tag_track #(.AD_W(AD_W), .ADDR_W(ADDR_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .inval      (port_disable),
      .mode16     (req_mode16),
      .addr       (req_addr),
      .need_latch (need_ale)
   );

   mux_ad_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .need_ale   (need_ale),
      .abort      (abort),
      .t_ale      (t_ale),
      .t_hold     (t_hold),
      .t_strobe   (t_strobe),
      .t_recover  (t_recover),
      .phase      (phase),
      .phase_last (phase_last)
   );

   mux_ad_lanes #(.AD_W(AD_W), .ADDR_W(ADDR_W)) u_lanes (
      .phase  (phase),
      .write  (q_write),
      .mode16 (q_mode16),
      .addr   (q_addr),
      .wdata  (q_wdata),
      .ad_out (lane_out),
      .ad_oe  (lane_oe)
   );

   assign cap = q_mode16 ? ad_in : {{(AD_W-8){1'b0}}, ad_in[7:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_addr   <= '0;
         q_wdata  <= '0;
         q_write  <= 1'b0;
         q_mode16 <= 1'b0;
         pol_q    <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (start) begin
            q_addr   <= req_addr;
            q_wdata  <= req_wdata;
            q_write  <= req_write;
            q_mode16 <= req_mode16;
         end
         if (phase == PH_IDLE) begin
            pol_q <= cfg_ale_low;
         end
         done_q <= reject || abort || finish;
         err_q  <= reject || abort;
         if (reject || abort || finish) begin
            rdata_q <= (finish && !q_write) ? cap : '0;
         end
      end
   end

   assign ale_pin   = ((phase == PH_ALE) && !port_disable) ^ pol_q;
   assign rd_n      = !((phase == PH_STROBE) && !q_write && !port_disable);
   assign wr_n      = !((phase == PH_STROBE) &&  q_write && !port_disable);
   assign ad_out    = lane_out;
   assign ad_oe     = port_disable ? '0 : lane_oe;
   assign rsp_done  = done_q;
   assign rsp_err   = err_q;
   assign rsp_rdata = rdata_q;

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R7
   hold_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) || $fell(wr_n)) |-> ($past(ad_oe) == {AD_W{1'b1}}));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R9
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_disable |-> (rd_n && wr_n && (ad_oe == '0) && (ale_pin == pol_q)));

   // R9
   reject_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && port_disable) |=> (rsp_done && rsp_err));

   // R10
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
endmodule

// File: tb/tb_mux_ad_port.sv
`timescale 1ns/1ps
module tb_mux_ad_port;
   typedef struct packed {
      logic        err;
      logic        rd;
      logic [15:0] data;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_ale_low = 1'b0;
   logic [3:0]  t_ale = 4'd1, t_hold = 4'd1, t_strobe = 4'd2, t_recover = 4'd1;
   logic        port_disable = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mode16 = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rsp_done, rsp_err, ale_pin, rd_n, wr_n;
   logic [15:0] rsp_rdata, ad_out, ad_oe, ad_in;

   int   checks = 0, errors = 0, resp_cnt = 0, issued = 0;
   bit   ended = 1'b0;
   exp_t sb[$];

   logic        tb_pol = 1'b0, cur16 = 1'b0;
   logic [15:0] ext_latch = '0, wr_seen = '0, rd_oe_seen = '0;
   int          n_ale, n_hold, n_rd, n_wr, n_rec;

   always #4 clk = ~clk;

   mux_ad_port dut (
      .clk(clk), .rst_n(rst_n), .cfg_ale_low(cfg_ale_low),
      .t_ale(t_ale), .t_hold(t_hold), .t_strobe(t_strobe), .t_recover(t_recover),
      .port_disable(port_disable), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mode16(req_mode16), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .ale_pin(ale_pin), .rd_n(rd_n), .wr_n(wr_n)
   );

   function automatic logic [7:0] mem8(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
   endfunction
   function automatic logic [15:0] mem16(input logic [15:0] a);
      return a ^ 16'h3C5A;
   endfunction
   function automatic int eff(input logic [3:0] t);
      return (t == 4'd0) ? 1 : int'(t);
   endfunction

   // external memory model driving the pins during a read strobe
   always_comb begin
      if (!rd_n) ad_in = cur16 ? mem16(ext_latch) : {8'hEE, mem8({ext_latch, ad_out[15:8]})};
      else       ad_in = 16'hDEAD;
   end

   // bus observer with the external address latch
   always @(negedge clk) begin
      if (rst_n) begin
         if (tb_pol ? !ale_pin : ale_pin) begin
            n_ale++;
            ext_latch <= ad_out;
         end
         if (!rd_n) begin n_rd++; rd_oe_seen <= ad_oe; end
         if (!wr_n) begin n_wr++; wr_seen <= ad_out; end
         if (!req_ready && ad_oe == 16'hFFFF && rd_n && wr_n && !(tb_pol ? !ale_pin : ale_pin)) n_hold++;
         if (!req_ready && ad_oe == 16'h0000 && rd_n && wr_n) n_rec++;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R8 unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_err == e.err, e.err ? "R9 error flag" : "R8 error flag", rsp_err, e.err);
            if (e.rd || e.err) chk(rsp_rdata == e.data, "R5 read data", rsp_rdata, e.data);
         end
         resp_cnt++;
      end
   end

   task automatic clear_obs();
      n_ale = 0; n_hold = 0; n_rd = 0; n_wr = 0; n_rec = 0;
   endtask

   task automatic issue(input logic w, input logic m16, input logic [23:0] a, input logic [15:0] wd);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_mode16 = m16; req_addr = a; req_wdata = wd;
      issued++;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_resp();
      while (resp_cnt != issued) @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic access(input logic w, input logic m16, input logic [23:0] a,
                         input logic [15:0] wd, input bit exp_ale);
      exp_t e;
      e.err = 1'b0;
      e.rd  = !w;
      e.data = w ? 16'h0 : (m16 ? mem16(a[15:0]) : {8'h00, mem8(a)});
      sb.push_back(e);
      cur16 = m16;
      clear_obs();
      issue(w, m16, a, wd);
      wait_resp();
      chk(n_ale == (exp_ale ? eff(t_ale) : 0), m16 ? "R3 latch phase cycles" : "R2 latch phase cycles",
          n_ale, exp_ale ? eff(t_ale) : 0);
      chk(ext_latch == (m16 ? a[15:0] : a[23:8]), m16 ? "R3 latched address" : "R2 latched address",
          ext_latch, m16 ? a[15:0] : a[23:8]);
      chk(n_hold == eff(t_hold), "R7 hold cycles", n_hold, eff(t_hold));
      chk(n_rec == eff(t_recover), "R7 recovery cycles", n_rec, eff(t_recover));
      if (w) begin
         chk(n_wr == eff(t_strobe) && n_rd == 0, "R6 write strobe cycles", n_wr, eff(t_strobe));
         chk(wr_seen == (m16 ? wd : {a[7:0], wd[7:0]}), "R6 write pins", wr_seen, m16 ? wd : {a[7:0], wd[7:0]});
      end else begin
         chk(n_rd == eff(t_strobe) && n_wr == 0, "R5 read strobe cycles", n_rd, eff(t_strobe));
         chk(rd_oe_seen == (m16 ? 16'h0000 : 16'hFF00), "R5 read pin release", rd_oe_seen, m16 ? 16'h0 : 16'hFF00);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         chk(1'b0, "watchdog", 0, 1);
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(ad_oe == 16'h0 && rd_n && wr_n && !ale_pin, "R1 pins in reset", {ad_oe, rd_n, wr_n, ale_pin}, 19'h6);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ad_oe == 16'h0 && rd_n && wr_n && !ale_pin, "R1 pins after reset", {ad_oe, rd_n, wr_n, ale_pin}, 19'h6);
      chk(req_ready && !rsp_done, "R1 R10 ready after reset", {req_ready, rsp_done}, 2'b10);

      // byte mode: first access latches, same upper bits skip, new upper bits latch
      access(1'b1, 1'b0, 24'h123456, 16'hBEA7, 1'b1);
      access(1'b0, 1'b0, 24'h1234A0, 16'h0, 1'b0);
      access(1'b0, 1'b0, 24'h1334A0, 16'h0, 1'b1);
      // word mode: width change latches, bits 23..16 ignored
      access(1'b0, 1'b1, 24'h00BEEF, 16'h0, 1'b1);
      access(1'b1, 1'b1, 24'h55BEEF, 16'hC0DE, 1'b0);
      access(1'b0, 1'b1, 24'h00BEF0, 16'h0, 1'b1);
      // longer phases, then zero lengths acting as one cycle
      t_ale = 4'd3; t_hold = 4'd2; t_strobe = 4'd4; t_recover = 4'd2;
      access(1'b0, 1'b0, 24'hABCD12, 16'h0, 1'b1);
      access(1'b1, 1'b0, 24'hABCD34, 16'h7788, 1'b0);
      t_ale = 4'd0; t_hold = 4'd0; t_strobe = 4'd0; t_recover = 4'd0;
      access(1'b0, 1'b1, 24'h001111, 16'h0, 1'b1);

      // R4 active-low latch strobe
      cfg_ale_low = 1'b1; tb_pol = 1'b1;
      repeat (2) @(negedge clk);
      chk(ale_pin == 1'b1, "R4 inactive level when active low", ale_pin, 1);
      access(1'b0, 1'b1, 24'h002222, 16'h0, 1'b1);
      cfg_ale_low = 1'b0; tb_pol = 1'b0;
      repeat (2) @(negedge clk);
      chk(ale_pin == 1'b0, "R4 inactive level when active high", ale_pin, 0);

      // R9 request while disabled
      port_disable = 1'b1;
      @(negedge clk);
      chk(rd_n && wr_n && ad_oe == 16'h0 && !ale_pin, "R9 quiet pins while disabled",
          {ad_oe, rd_n, wr_n, ale_pin}, 19'h6);
      begin
         exp_t e;
         e.err = 1'b1; e.rd = 1'b0; e.data = 16'h0;
         sb.push_back(e);
      end
      clear_obs();
      issue(1'b1, 1'b1, 24'h002222, 16'h1234);
      chk(rsp_done && rsp_err, "R9 immediate error response", {rsp_done, rsp_err}, 2'b11);
      wait_resp();
      chk(n_ale == 0 && n_rd == 0 && n_wr == 0, "R9 no bus activity", n_ale + n_rd + n_wr, 0);
      port_disable = 1'b0;
      @(negedge clk);
      // R9 disable forgot the latch: same address latches again
      access(1'b0, 1'b1, 24'h002222, 16'h0, 1'b1);

      // R9 abort in the middle of a long strobe
      t_ale = 4'd1; t_hold = 4'd1; t_strobe = 4'd8; t_recover = 4'd1;
      begin
         exp_t e;
         e.err = 1'b1; e.rd = 1'b0; e.data = 16'h0;
         sb.push_back(e);
      end
      cur16 = 1'b1;
      issue(1'b0, 1'b1, 24'h002222, 16'h0);
      chk(!req_ready, "R10 not ready during access", req_ready, 0);
      repeat (3) @(negedge clk);
      chk(!rd_n, "R5 strobe active before abort", rd_n, 0);
      port_disable = 1'b1;
      @(negedge clk);
      chk(rd_n && ad_oe == 16'h0, "R9 strobe dropped on disable", {rd_n, ad_oe}, 17'h10000);
      wait_resp();
      port_disable = 1'b0;
      @(negedge clk);
      t_strobe = 4'd2;
      access(1'b0, 1'b1, 24'h002222, 16'h0, 1'b1);

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R8 all responses seen", sb.size(), 0);
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule